// File: doc/BRIEF.md
# Long-press pushbutton reset controller

This block turns a deliberate, long press on one or two front-panel buttons into a single active-low system reset pulse of fixed length. Short or accidental presses are filtered out by a long setup count. After the pulse, the block stays disarmed until the buttons have been cleanly released, so a held button cannot cause repeated resets. The same output also serves as a power supervisor output. It is forced low while an undervoltage flag is active. After the supply recovers, it is held low for one full timeout.

All timing is counted in clock cycles and set by parameters. The button inputs and the supply-good flag are asynchronous and pass through two-flop synchronizers. A single counter is shared by the setup, pulse/timeout and release-debounce phases, because only one of them is active at any time. The supply-good flag also acts as the block's reset. It clears the block at once when it drops and releases it in step with the clock when it returns. In dual mode both buttons must be held together. In single mode only the first button is used.

Top module: `lp_reset_ctrl`

## Requirements
- R1: While `pwr_ok` is low, `rst_out_n` is low. A fall of `pwr_ok` drives `rst_out_n` low without waiting for a clock edge.
- R2: After `pwr_ok` returns high, `rst_out_n` stays low for HOLD_CYC+1 clock cycles (synchronizer latency included) and then goes high. With the buttons released it then stays high.
- R3: A press shorter than SETUP_CYC consecutive clock cycles produces no pulse. A press of exactly SETUP_CYC cycles produces a pulse.
- R4: Every button-initiated pulse holds `rst_out_n` low for exactly HOLD_CYC clock cycles.
- R5: A valid press produces exactly one pulse, however long the buttons stay held after it.
- R6: After a pulse, the block re-arms only after a release (input high) lasting DEB_CYC consecutive cycles. A shorter high interval followed by a new low leaves the block disarmed.
- R7: With DUAL=1, both buttons must be low together for the whole setup count. One button held alone never fires, and a one-cycle high on either button cancels and restarts the count.
- R8: With DUAL=1, a debounced release of only one of the two buttons is enough to re-arm.
- R9: With DUAL=0, `btn_b_n` has no effect on `rst_out_n`.
- R10: If `pwr_ok` falls during a button pulse, `rst_out_n` stays low. After recovery the full HOLD_CYC+1 timeout of R2 applies, and no extra pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all counts are in its cycles |
| pwr_ok | input | 1 | Asynchronous supply-good flag; low means undervoltage |
| btn_a_n | input | 1 | First pushbutton, active low, high when released or undriven |
| btn_b_n | input | 1 | Second pushbutton, active low; used only when DUAL=1 |
| rst_out_n | output | 1 | Active-low system reset output |

## Verification
The bench sweeps press length across the setup boundary. An off-by-one setup counter would fire one cycle early or require one cycle too many. It measures every pulse width, which catches a timeout that is short or long by a cycle. It bounces the release for every length up to one cycle past the debounce period. A debounce that re-arms early, or that fails to restart on a glitch, gives a second pulse where none is due. In dual mode it holds a single button alone, glitches one button mid-count and releases only one button. A design that ORs the buttons, fails to cancel the count, or demands that both buttons be released is caught by one of these. Dropping the supply in the middle of a pulse exposes a timeout that resumes instead of restarting, and one that re-fires after recovery.

// File: rtl/lp_rst_pkg.sv
package lp_rst_pkg;

    // Controller phases; the reset value is the undervoltage hold.
    typedef enum logic [2:0] {
        ST_UV_HOLD  = 3'd0,
        ST_IDLE     = 3'd1,
        ST_SETUP    = 3'd2,
        ST_PULSE    = 3'd3,
        ST_WAIT_REL = 3'd4
    } state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/lp_sync.sv
module lp_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] sh_d;
    logic [STAGES-1:0] sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= {STAGES{RST_VAL}};
        end else begin
            sh_q <= sh_d;
        end
    end

    assign q = sh_q[STAGES-1];

endmodule

// File: rtl/lp_rst_fsm.sv
module lp_rst_fsm
    import lp_rst_pkg::*;
#(
    parameter bit DUAL      = 1'b1,
    parameter int SETUP_CYC = 8,
    parameter int HOLD_CYC  = 6,
    parameter int DEB_CYC   = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   btn_a_s,
    input  logic   btn_b_s,
    output state_e state_o,
    output logic   out_n_o
);

    localparam int CNT_MAX = max3(SETUP_CYC, HOLD_CYC, DEB_CYC);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] DEB_LAST   = CNT_W'(DEB_CYC - 1);
    localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

    typedef struct packed {
        state_e           state;
        logic [CNT_W-1:0] cnt;
        logic             out_n;
    } regs_t;

    localparam regs_t RST_REGS = '{state: ST_UV_HOLD, cnt: '0, out_n: 1'b0};

    regs_t r_d;
    regs_t r_q;
    logic  pressed;
    logic  freed;

    // R7: dual mode needs both buttons down; one button up counts as freed (R8).
    generate
        if (DUAL) begin : g_dual
            assign pressed = !btn_a_s && !btn_b_s;
            assign freed   = btn_a_s || btn_b_s;
        end else begin : g_single
            assign pressed = !btn_a_s;
            assign freed   = btn_a_s;
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_UV_HOLD: begin
                // R2: full timeout after the supply flag recovers
                r_d.out_n = 1'b0;
                if (r_q.cnt == HOLD_LAST) begin
                    r_d.state = ST_IDLE;
                    r_d.cnt   = '0;
                    r_d.out_n = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + ONE;
                end
            end
            ST_IDLE: begin
                r_d.out_n = 1'b1;
                if (pressed) begin
                    r_d.state = ST_SETUP;
                    r_d.cnt   = ONE;
                end
            end
            ST_SETUP: begin
                // R3: consecutive pressed samples; any gap cancels
                if (!pressed) begin
                    r_d.state = ST_IDLE;
                    r_d.cnt   = '0;
                end else if (r_q.cnt == SETUP_LAST) begin
                    r_d.state = ST_PULSE;
                    r_d.cnt   = '0;
                    r_d.out_n = 1'b0;
                end else begin
                    r_d.cnt = r_q.cnt + ONE;
                end
            end
            ST_PULSE: begin
                // R4: fixed-length pulse, buttons ignored meanwhile
                if (r_q.cnt == HOLD_LAST) begin
                    r_d.state = ST_WAIT_REL;
                    r_d.cnt   = '0;
                    r_d.out_n = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + ONE;
                end
            end
            ST_WAIT_REL: begin
                // R5, R6: stay disarmed until a debounced release
                if (!freed) begin
                    r_d.cnt = '0;
                end else if (r_q.cnt == DEB_LAST) begin
                    r_d.state = ST_IDLE;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + ONE;
                end
            end
            default: begin
                r_d = RST_REGS;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= RST_REGS;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.state;
    assign out_n_o = r_q.out_n;

endmodule

// File: rtl/lp_reset_ctrl.sv
module lp_reset_ctrl
    import lp_rst_pkg::*;
#(
    parameter bit DUAL        = 1'b1,
    parameter int SETUP_CYC   = 2_000_000,
    parameter int HOLD_CYC    = 200_000,
    parameter int DEB_CYC     = 20_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic pwr_ok,
    input  logic btn_a_n,
    input  logic btn_b_n,
    output logic rst_out_n
);

    localparam int NUM_BTN = DUAL ? 2 : 1;

    logic       pg_s;
    logic [1:0] btn_raw;
    logic [1:0] btn_s;
    state_e     fsm_state;
    logic       fsm_out_n;

    // R1: supply flag clears the block at once, releases it synchronously
    lp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pg_sync (
        .clk   (clk),
        .rst_n (pwr_ok),
        .d     (1'b1),
        .q     (pg_s)
    );

    assign btn_raw = {btn_b_n, btn_a_n};

    // R9: in single mode the second button gets no synchronizer and reads released
    generate
        for (genvar i = 0; i < 2; i++) begin : g_btn
            if (i < NUM_BTN) begin : g_used
                lp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_btn_sync (
                    .clk   (clk),
                    .rst_n (pg_s),
                    .d     (btn_raw[i]),
                    .q     (btn_s[i])
                );
            end else begin : g_tied
                assign btn_s[i] = 1'b1;
            end
        end
    endgenerate

    lp_rst_fsm #(
        .DUAL      (DUAL),
        .SETUP_CYC (SETUP_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .DEB_CYC   (DEB_CYC)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (pg_s),
        .btn_a_s (btn_s[0]),
        .btn_b_s (btn_s[1]),
        .state_o (fsm_state),
        .out_n_o (fsm_out_n)
    );

    assign rst_out_n = fsm_out_n;

endmodule

// File: rtl/lp_reset_chk.sv
module lp_reset_chk
    import lp_rst_pkg::*;
#(
    parameter bit DUAL     = 1'b1,
    parameter int HOLD_CYC = 6
) (
    input logic   clk,
    input logic   pg,
    input logic   rst_out_n,
    input logic   btn_a_s,
    input logic   btn_b_s,
    input state_e st
);

    int unsigned low_cnt;

    always_ff @(posedge clk or negedge pg) begin
        if (!pg) begin
            low_cnt <= 0;
        end else if (!rst_out_n) begin
            low_cnt <= low_cnt + 1;
        end else begin
            low_cnt <= 0;
        end
    end

    // R1
    uv_forces_low_chk: assert property (@(posedge clk) !pg |-> !rst_out_n);

    // R4
    pulse_width_chk: assert property (@(posedge clk) disable iff (!pg)
        $rose(rst_out_n) |-> (low_cnt == HOLD_CYC));

    // R7
    setup_needs_press_chk: assert property (@(posedge clk) disable iff (!pg)
        (st == ST_SETUP) |->
            (DUAL ? (!$past(btn_a_s) && !$past(btn_b_s)) : !$past(btn_a_s)));

    // R5
    pulse_from_setup_chk: assert property (@(posedge clk) disable iff (!pg)
        (st == ST_PULSE && $past(st) != ST_PULSE) |-> ($past(st) == ST_SETUP));

    // R6
    rearm_on_release_chk: assert property (@(posedge clk) disable iff (!pg)
        (st == ST_IDLE && $past(st) == ST_WAIT_REL) |->
            (DUAL ? ($past(btn_a_s) || $past(btn_b_s)) : $past(btn_a_s)));

    // R6
    wait_output_high_chk: assert property (@(posedge clk) disable iff (!pg)
        (st == ST_WAIT_REL) |-> rst_out_n);

endmodule

bind lp_reset_ctrl lp_reset_chk #(
    .DUAL     (DUAL),
    .HOLD_CYC (HOLD_CYC)
) u_lp_reset_chk (
    .clk       (clk),
    .pg        (pg_s),
    .rst_out_n (rst_out_n),
    .btn_a_s   (btn_s[0]),
    .btn_b_s   (btn_s[1]),
    .st        (fsm_state)
);

// File: tb/test_lp_reset_ctrl.sv
`timescale 1ns/1ps
module test_lp_reset_ctrl;

    localparam int SETUP_CYC = 8;
    localparam int HOLD_CYC  = 6;
    localparam int DEB_CYC   = 4;
    localparam int SYNC      = 2;
    localparam int GAP       = SETUP_CYC + HOLD_CYC + DEB_CYC + 8;
    localparam int LONG      = SETUP_CYC + HOLD_CYC + 4;
    localparam int RECOVER   = HOLD_CYC + SYNC - 1;

    logic clk     = 1'b0;
    logic pwr_ok  = 1'b0;
    logic btn_a_n = 1'b1;
    logic btn_b_n = 1'b1;
    logic rst_dual_n;
    logic rst_single_n;

    int checks = 0;
    int fails  = 0;
    int falls[2];
    int run_len[2];
    int last_len[2];
    logic prev_n[2];

    always #4 clk = ~clk;

    lp_reset_ctrl #(
        .DUAL(1'b1), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC),
        .DEB_CYC(DEB_CYC), .SYNC_STAGES(SYNC)
    ) i_lp_reset_ctrl (
        .clk(clk), .pwr_ok(pwr_ok), .btn_a_n(btn_a_n), .btn_b_n(btn_b_n),
        .rst_out_n(rst_dual_n)
    );

    lp_reset_ctrl #(
        .DUAL(1'b0), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC),
        .DEB_CYC(DEB_CYC), .SYNC_STAGES(SYNC)
    ) i_lp_reset_ctrl_single (
        .clk(clk), .pwr_ok(pwr_ok), .btn_a_n(btn_a_n), .btn_b_n(btn_b_n),
        .rst_out_n(rst_single_n)
    );

    initial begin
        for (int i = 0; i < 2; i++) begin
            falls[i] = 0; run_len[i] = 0; last_len[i] = 0; prev_n[i] = 1'b0;
        end
    end

    // Pulse monitor: counts falling edges and the low length of the last pulse
    always @(negedge clk) begin
        logic now_n[2];
        now_n[0] = rst_dual_n;
        now_n[1] = rst_single_n;
        for (int i = 0; i < 2; i++) begin
            if (!now_n[i]) begin
                if (prev_n[i]) begin
                    falls[i]   = falls[i] + 1;
                    run_len[i] = 1;
                end else begin
                    run_len[i] = run_len[i] + 1;
                end
            end else if (!prev_n[i]) begin
                last_len[i] = run_len[i];
            end
            prev_n[i] = now_n[i];
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic clr();
        for (int i = 0; i < 2; i++) begin
            falls[i] = 0;
            last_len[i] = 0;
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic press(input bit use_a, input bit use_b, input int n);
        if (use_a) btn_a_n = 1'b0;
        if (use_b) btn_b_n = 1'b0;
        tick(n);
        btn_a_n = 1'b1;
        btn_b_n = 1'b1;
        tick(GAP);
    endtask

    // Raise the supply flag and count low samples on each output
    task automatic recover(output int n_dual, output int n_single);
        bit done_d;
        bit done_s;
        pwr_ok   = 1'b1;
        n_dual   = 0;
        n_single = 0;
        done_d   = 1'b0;
        done_s   = 1'b0;
        for (int c = 0; c < 200 && !(done_d && done_s); c++) begin
            @(negedge clk);
            if (!done_d) begin
                if (rst_dual_n) done_d = 1'b1; else n_dual++;
            end
            if (!done_s) begin
                if (rst_single_n) done_s = 1'b1; else n_single++;
            end
        end
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int nd;
        int ns;
        int exp_d;

        // Reset state and power-up timeout (R1, R2)
        tick(3);
        chk("R1", "dual low at power-up", int'(rst_dual_n), 0);
        chk("R1", "single low at power-up", int'(rst_single_n), 0);
        recover(nd, ns);
        chk("R2", "dual power-up low length", nd, RECOVER);
        chk("R2", "single power-up low length", ns, RECOVER);
        clr();
        tick(GAP);
        chk("R2", "dual stays high idle", int'(rst_dual_n), 1);
        chk("R2", "no pulses while idle", falls[0] + falls[1], 0);

        // Press-length sweep across the setup boundary (R3, R4)
        for (int n = 1; n <= SETUP_CYC + 2; n++) begin
            clr();
            press(1'b1, 1'b1, n);
            exp_d = (n >= SETUP_CYC) ? 1 : 0;
            chk("R3", $sformatf("dual pulses for press %0d", n), falls[0], exp_d);
            chk("R3", $sformatf("single pulses for press %0d", n), falls[1], exp_d);
            if (exp_d == 1) begin
                chk("R4", "dual pulse width", last_len[0], HOLD_CYC);
                chk("R4", "single pulse width", last_len[1], HOLD_CYC);
            end
        end

        // Continued hold gives one pulse only (R5)
        clr();
        press(1'b1, 1'b1, 3 * LONG);
        chk("R5", "dual single pulse on long hold", falls[0], 1);
        chk("R5", "single single pulse on long hold", falls[1], 1);

        // One button alone (R7, R9)
        clr();
        press(1'b1, 1'b0, LONG);
        chk("R7", "dual with first button only", falls[0], 0);
        chk("R9", "single with first button", falls[1], 1);
        clr();
        press(1'b0, 1'b1, LONG);
        chk("R7", "dual with second button only", falls[0], 0);
        chk("R9", "single ignores second button", falls[1], 0);

        // Glitch on one button cancels the dual count (R7)
        for (int last = SETUP_CYC - 1; last <= SETUP_CYC; last++) begin
            clr();
            btn_a_n = 1'b0;
            btn_b_n = 1'b0;
            tick(SETUP_CYC - 1);
            btn_b_n = 1'b1;
            tick(1);
            btn_b_n = 1'b0;
            tick(last);
            btn_a_n = 1'b1;
            btn_b_n = 1'b1;
            tick(GAP);
            chk("R7", $sformatf("dual after glitch, tail %0d", last), falls[0],
                (last >= SETUP_CYC) ? 1 : 0);
            chk("R9", "single unaffected by second-button glitch", falls[1], 1);
        end

        // Bouncing full release: re-arm only after DEB_CYC high cycles (R6)
        for (int k = 1; k <= DEB_CYC + 1; k++) begin
            clr();
            btn_a_n = 1'b0;
            btn_b_n = 1'b0;
            tick(LONG);
            btn_a_n = 1'b1;
            btn_b_n = 1'b1;
            tick(k);
            btn_a_n = 1'b0;
            btn_b_n = 1'b0;
            tick(LONG);
            btn_a_n = 1'b1;
            btn_b_n = 1'b1;
            tick(GAP);
            exp_d = 1 + ((k >= DEB_CYC) ? 1 : 0);
            chk("R6", $sformatf("dual pulses, release of %0d", k), falls[0], exp_d);
            chk("R6", $sformatf("single pulses, release of %0d", k), falls[1], exp_d);
        end

        // Partial release of the second button only (R8, R9)
        for (int k = 1; k <= DEB_CYC + 1; k++) begin
            clr();
            btn_a_n = 1'b0;
            btn_b_n = 1'b0;
            tick(LONG);
            btn_b_n = 1'b1;
            tick(k);
            btn_b_n = 1'b0;
            tick(LONG);
            btn_a_n = 1'b1;
            btn_b_n = 1'b1;
            tick(GAP);
            chk("R8", $sformatf("dual pulses, one-button release %0d", k), falls[0],
                1 + ((k >= DEB_CYC) ? 1 : 0));
            chk("R9", $sformatf("single pulses, second-button release %0d", k), falls[1], 1);
        end

        // Immediate undervoltage response (R1, R2)
        pwr_ok = 1'b0;
        #1;
        chk("R1", "dual low right after supply drop", int'(rst_dual_n), 0);
        chk("R1", "single low right after supply drop", int'(rst_single_n), 0);
        btn_a_n = 1'b0;
        btn_b_n = 1'b0;
        tick(LONG);
        chk("R1", "dual held low under undervoltage", int'(rst_dual_n), 0);
        btn_a_n = 1'b1;
        btn_b_n = 1'b1;
        tick(2);
        recover(nd, ns);
        chk("R2", "dual recovery low length", nd, RECOVER);
        chk("R2", "single recovery low length", ns, RECOVER);
        clr();
        tick(GAP);
        chk("R2", "no pulse after recovery", falls[0] + falls[1], 0);

        // Supply drop in the middle of a button pulse (R10)
        clr();
        btn_a_n = 1'b0;
        btn_b_n = 1'b0;
        tick(SETUP_CYC + 3);
        chk("R10", "dual pulse running before drop", int'(rst_dual_n), 0);
        pwr_ok = 1'b0;
        tick(2);
        btn_a_n = 1'b1;
        btn_b_n = 1'b1;
        tick(2);
        chk("R10", "dual low during drop", int'(rst_dual_n), 0);
        recover(nd, ns);
        chk("R10", "dual timeout restarts", nd, RECOVER);
        chk("R10", "single timeout restarts", ns, RECOVER);
        tick(GAP);
        chk("R10", "dual one fall only", falls[0], 1);
        chk("R10", "single one fall only", falls[1], 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule